// File: doc/BRIEF.md
# Hardwired Step-Sequenced Control Unit

This block is the control unit for a processor that moves data over a single internal bus. A step counter advances on each enabled clock and is decoded into one-hot timing lines, one for each step of an instruction. An opcode decoder turns the instruction register's opcode field into one-hot instruction-class lines. A combinational encoder then builds each register strobe, ALU command and memory command as an OR of step-AND-class terms, with the zero condition flag gating one branch class.

Every instruction begins with the same three-step fetch. The steps that follow depend on the opcode. A step that waits for memory freezes the counter until the memory reports completion. The done strobe sends the counter back to the first step on the next enabled clock. A run input can stop the sequence altogether.

Top module: `hw_seq_ctrl`

## Requirements
- R1: After synchronous reset, the unit is in step 1 and drives the step-1 fetch strobes listed in R2.
- R2: Step 1 asserts pc_out, mar_in, mem_rd, y_clr, carry_in, alu_add and z_in, and nothing else, for any opcode.
- R3: Step 2 asserts z_out, pc_in and wait_mem. Step 3 asserts mdr_out and ir_in. No other strobe is active in either step.
- R4: Opcode 0 (add from memory) asserts r3_out, mar_in and mem_rd in step 4. Step 5 asserts r1_out, y_in and wait_mem. Step 6 asserts mdr_out, alu_add and z_in. Step 7 asserts z_out, r1_in and done.
- R5: Opcode 1 (relative jump) asserts pc_out and y_in in step 4. Step 5 asserts r3_out, alu_add and z_in. Step 6 asserts z_out, pc_in and done.
- R6: Opcode 2 (branch if zero) follows the R5 sequence when cond_zero is 1. When cond_zero is 0 it asserts only done, in step 4.
- R7: Opcode 3 (store) asserts r3_out and mar_in in step 4. Step 5 asserts r1_out, mdr_in, mem_wr and wait_mem. Step 6 asserts only done. mem_rd and mem_wr are never active together.
- R8: Any opcode from 4 to 15 asserts only done in step 4.
- R9: While wait_mem is active and mem_done is 0, the step does not advance, and the same strobes stay active.
- R10: While run is 0 the step does not change.
- R11: After an enabled clock on which done is active, the unit is in step 1.
- R12: The opcode has no effect on the strobes during steps 1 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Enables step advance |
| opcode | input | OPC_W | Opcode field of the instruction register |
| cond_zero | input | 1 | Zero condition flag |
| mem_done | input | 1 | Memory function complete |
| pc_out | output | 1 | PC drives bus |
| pc_in | output | 1 | PC loads from bus |
| mar_in | output | 1 | Address register loads |
| mdr_out | output | 1 | Data register drives bus |
| mdr_in | output | 1 | Data register loads from bus |
| ir_in | output | 1 | Instruction register loads |
| y_in | output | 1 | ALU operand register loads |
| y_clr | output | 1 | ALU operand register cleared |
| z_in | output | 1 | ALU result register loads |
| z_out | output | 1 | ALU result register drives bus |
| r1_in | output | 1 | Register 1 loads |
| r1_out | output | 1 | Register 1 drives bus |
| r3_out | output | 1 | Register 3 drives bus |
| alu_add | output | 1 | ALU adds |
| carry_in | output | 1 | ALU carry input set |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| wait_mem | output | 1 | Step waits for memory completion |
| done | output | 1 | Last step of the instruction |

## Verification
The bench runs every opcode with both values of the zero flag and with memory completion delays of zero, one and two cycles. It also pauses run at points spread through the sequences. A counter that ignored the memory wait would skip past the memory wait in steps 2 and 5 and release strobes early. One that ignored run would advance through the pauses. One that failed to restart on done would reach an extra step with no strobes, or step 8. Changing the opcode at every fetch shows whether any fetch strobe leaks an opcode term. The not-taken branch and the undefined opcodes check that done comes at step 4 and nothing else is driven.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int unsigned OPC_ADD = 0;
  localparam int unsigned OPC_JMP = 1;
  localparam int unsigned OPC_BRZ = 2;
  localparam int unsigned OPC_STR = 3;
  localparam int unsigned NKNOWN  = 4;
  localparam int unsigned NCLS    = NKNOWN + 1;  // last line: undefined opcode
  localparam int unsigned CLS_UNK = NKNOWN;

  typedef struct packed {
    logic pc_out, pc_in, mar_in, mdr_out, mdr_in, ir_in;
    logic y_in, y_clr, z_in, z_out, r1_in, r1_out, r3_out;
    logic alu_add, carry_in, mem_rd, mem_wr, wait_mem, done;
  } ctl_t;
endpackage

// File: rtl/step_ctr.sv
module step_ctr #(
  parameter int unsigned NSTEP = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             hold,
  input  logic             fin,
  output logic [NSTEP-1:0] t
);
  localparam int unsigned IDX_W = (NSTEP > 1) ? $clog2(NSTEP) : 1;
  logic [IDX_W-1:0] idx;

  always_ff @(posedge clk) begin
    if (rst) idx <= '0;
    else if (run) begin
      if (fin) idx <= '0;
      else if (!hold) idx <= (idx == IDX_W'(NSTEP - 1)) ? '0 : idx + 1'b1;
    end
  end

  for (genvar g = 0; g < NSTEP; g++) begin : g_dec
    assign t[g] = (idx == IDX_W'(g));
  end

  p_step_onehot_r1: assert property (@(posedge clk) disable iff (rst) $countones(t) == 1);
  p_hold_wait_r9: assert property (@(posedge clk) disable iff (rst) (run && hold && !fin) |=> $stable(t));
  p_run_low_r10: assert property (@(posedge clk) disable iff (rst) !run |=> $stable(t));
  p_end_restart_r11: assert property (@(posedge clk) disable iff (rst) (run && fin) |=> t[0]);
endmodule

// File: rtl/op_decode.sv
module op_decode
  import ctl_pkg::*;
#(
  parameter int unsigned OPC_W = 4
) (
  input  logic [OPC_W-1:0] opcode,
  output logic [NCLS-1:0]  cls
);
  logic [NKNOWN-1:0] hit;

  for (genvar k = 0; k < NKNOWN; k++) begin : g_hit
    assign hit[k] = (opcode == OPC_W'(k));
  end

  assign cls = {~|hit, hit};
endmodule

// File: rtl/ctl_encode.sv
module ctl_encode
  import ctl_pkg::*;
#(
  parameter int unsigned NSTEP = 7
) (
  input  logic [NSTEP-1:0] t,
  input  logic [NCLS-1:0]  cls,
  input  logic             zf,
  output ctl_t             c
);
  logic add_i, str_i, jmp_like, brz_nt, unk_i;

  always_comb begin
    add_i    = cls[OPC_ADD];
    str_i    = cls[OPC_STR];
    jmp_like = cls[OPC_JMP] | (cls[OPC_BRZ] & zf);
    brz_nt   = cls[OPC_BRZ] & ~zf;
    unk_i    = cls[CLS_UNK];

    c.pc_out   = t[0] | (t[3] & jmp_like);
    c.pc_in    = t[1] | (t[5] & jmp_like);
    c.mar_in   = t[0] | (t[3] & (add_i | str_i));
    c.mdr_out  = t[2] | (t[5] & add_i);
    c.mdr_in   = t[4] & str_i;
    c.ir_in    = t[2];
    c.y_in     = (t[4] & add_i) | (t[3] & jmp_like);
    c.y_clr    = t[0];
    c.z_in     = t[0] | (t[5] & add_i) | (t[4] & jmp_like);
    c.z_out    = t[1] | (t[6] & add_i) | (t[5] & jmp_like);
    c.r1_in    = t[6] & add_i;
    c.r1_out   = t[4] & (add_i | str_i);
    c.r3_out   = (t[3] & (add_i | str_i)) | (t[4] & jmp_like);
    c.alu_add  = t[0] | (t[5] & add_i) | (t[4] & jmp_like);
    c.carry_in = t[0];
    c.mem_rd   = t[0] | (t[3] & add_i);
    c.mem_wr   = t[4] & str_i;
    c.wait_mem = t[1] | (t[4] & (add_i | str_i));
    c.done     = (t[6] & add_i) | (t[5] & (jmp_like | str_i)) | (t[3] & (unk_i | brz_nt));
  end
endmodule

// File: rtl/hw_seq_ctrl.sv
module hw_seq_ctrl
  import ctl_pkg::*;
#(
  parameter int unsigned OPC_W = 4,
  parameter int unsigned NSTEP = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [OPC_W-1:0] opcode,
  input  logic             cond_zero,
  input  logic             mem_done,
  output logic             pc_out,
  output logic             pc_in,
  output logic             mar_in,
  output logic             mdr_out,
  output logic             mdr_in,
  output logic             ir_in,
  output logic             y_in,
  output logic             y_clr,
  output logic             z_in,
  output logic             z_out,
  output logic             r1_in,
  output logic             r1_out,
  output logic             r3_out,
  output logic             alu_add,
  output logic             carry_in,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic             wait_mem,
  output logic             done
);
  logic [NSTEP-1:0] t;
  logic [NCLS-1:0]  cls;
  ctl_t             c;
  logic             hold;

  assign hold = c.wait_mem & ~mem_done;

  step_ctr #(.NSTEP(NSTEP)) u_step (
    .clk(clk), .rst(rst), .run(run), .hold(hold), .fin(c.done), .t(t)
  );

  op_decode #(.OPC_W(OPC_W)) u_dec (.opcode(opcode), .cls(cls));

  ctl_encode #(.NSTEP(NSTEP)) u_enc (.t(t), .cls(cls), .zf(cond_zero), .c(c));

  assign {pc_out, pc_in, mar_in, mdr_out, mdr_in, ir_in} =
         {c.pc_out, c.pc_in, c.mar_in, c.mdr_out, c.mdr_in, c.ir_in};
  assign {y_in, y_clr, z_in, z_out, r1_in, r1_out, r3_out} =
         {c.y_in, c.y_clr, c.z_in, c.z_out, c.r1_in, c.r1_out, c.r3_out};
  assign {alu_add, carry_in, mem_rd, mem_wr, wait_mem, done} =
         {c.alu_add, c.carry_in, c.mem_rd, c.mem_wr, c.wait_mem, c.done};

  p_cls_onehot_r8: assert property (@(posedge clk) disable iff (rst) $countones(cls) == 1);
  p_rw_excl_r7: assert property (@(posedge clk) disable iff (rst) !(mem_rd && mem_wr));
  p_fetch_no_end_r12: assert property (@(posedge clk) disable iff (rst) (ir_in || y_clr) |-> !done);
endmodule

// File: tb/hw_seq_ctrl_bench.sv
module hw_seq_ctrl_bench;
  localparam int CLK_P = 10;
  localparam int B_PCO = 18, B_PCI = 17, B_MARI = 16, B_MDRO = 15, B_MDRI = 14, B_IRI = 13;
  localparam int B_YI = 12, B_YCLR = 11, B_ZI = 10, B_ZO = 9, B_R1I = 8, B_R1O = 7, B_R3O = 6;
  localparam int B_ADD = 5, B_CIN = 4, B_RD = 3, B_WR = 2, B_WM = 1, B_END = 0;

  logic clk = 0, rst = 1, run = 0, cond_zero = 0, mem_done = 0;
  logic [3:0] opcode = '0;
  logic pc_out, pc_in, mar_in, mdr_out, mdr_in, ir_in, y_in, y_clr, z_in, z_out;
  logic r1_in, r1_out, r3_out, alu_add, carry_in, mem_rd, mem_wr, wait_mem, done;
  int total = 0, bad = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  hw_seq_ctrl u_hw_seq_ctrl (
    .clk(clk), .rst(rst), .run(run), .opcode(opcode), .cond_zero(cond_zero), .mem_done(mem_done),
    .pc_out(pc_out), .pc_in(pc_in), .mar_in(mar_in), .mdr_out(mdr_out), .mdr_in(mdr_in),
    .ir_in(ir_in), .y_in(y_in), .y_clr(y_clr), .z_in(z_in), .z_out(z_out), .r1_in(r1_in),
    .r1_out(r1_out), .r3_out(r3_out), .alu_add(alu_add), .carry_in(carry_in),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .wait_mem(wait_mem), .done(done)
  );

  function automatic logic [18:0] got_vec();
    return {pc_out, pc_in, mar_in, mdr_out, mdr_in, ir_in, y_in, y_clr, z_in, z_out,
            r1_in, r1_out, r3_out, alu_add, carry_in, mem_rd, mem_wr, wait_mem, done};
  endfunction

  // expected strobes for 1-based step s
  function automatic logic [18:0] model(int s, int op, bit zf);
    logic [18:0] v = '0;
    if (s == 1) begin
      v[B_PCO] = 1; v[B_MARI] = 1; v[B_RD] = 1; v[B_YCLR] = 1; v[B_CIN] = 1; v[B_ADD] = 1; v[B_ZI] = 1;
    end else if (s == 2) begin
      v[B_ZO] = 1; v[B_PCI] = 1; v[B_WM] = 1;
    end else if (s == 3) begin
      v[B_MDRO] = 1; v[B_IRI] = 1;
    end else if (op == 0) begin
      if (s == 4) begin v[B_R3O] = 1; v[B_MARI] = 1; v[B_RD] = 1; end
      if (s == 5) begin v[B_R1O] = 1; v[B_YI] = 1; v[B_WM] = 1; end
      if (s == 6) begin v[B_MDRO] = 1; v[B_ADD] = 1; v[B_ZI] = 1; end
      if (s == 7) begin v[B_ZO] = 1; v[B_R1I] = 1; v[B_END] = 1; end
    end else if (op == 1 || (op == 2 && zf)) begin
      if (s == 4) begin v[B_PCO] = 1; v[B_YI] = 1; end
      if (s == 5) begin v[B_R3O] = 1; v[B_ADD] = 1; v[B_ZI] = 1; end
      if (s == 6) begin v[B_ZO] = 1; v[B_PCI] = 1; v[B_END] = 1; end
    end else if (op == 3) begin
      if (s == 4) begin v[B_R3O] = 1; v[B_MARI] = 1; end
      if (s == 5) begin v[B_R1O] = 1; v[B_MDRI] = 1; v[B_WR] = 1; v[B_WM] = 1; end
      if (s == 6) v[B_END] = 1;
    end else begin
      if (s == 4) v[B_END] = 1;
    end
    return v;
  endfunction

  function automatic string tag(int s, int op, int why);
    if (why == 1) return "R11";
    if (why == 2) return "R9";
    if (why == 3) return "R10";
    if (why == 4) return "R1";
    if (s == 1) return "R2/R12";
    if (s <= 3) return "R3/R12";
    case (op)
      0: return "R4";
      1: return "R5";
      2: return "R6";
      3: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string t, logic [18:0] got, logic [18:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b", t, got, exp);
    end
  endtask

  // run one instruction through the unit; returns when it is back at step 1
  task automatic run_instr(int op, bit zf, int delay);
    int s = 1, wc = 0, why = 0;
    bit ended = 0;
    logic [18:0] e;
    while (!ended) begin
      @(negedge clk);
      cyc++;
      opcode = 4'(op);
      cond_zero = zf;
      run = (cyc % 5 != 2);
      e = model(s, op, zf);
      mem_done = (wc >= delay);
      #1;
      chk(tag(s, op, why), got_vec(), e);
      @(posedge clk);
      why = 0;
      if (!run) why = 3;
      else if (e[B_END]) begin s = 1; why = 1; ended = 1; end
      else if (e[B_WM] && !mem_done) begin wc++; why = 2; end
      else begin
        if (e[B_WM]) wc = 0;
        s++;
      end
    end
    // first cycle after done: step 1 (R11)
    @(negedge clk);
    run = 0;
    #1;
    chk("R11", got_vec(), model(1, op, zf));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    opcode = 4'd9;
    #1;
    chk("R1", got_vec(), model(1, 9, 0));
    for (int d = 0; d < 3; d++)
      for (int op = 0; op < 16; op++)
        for (int z = 0; z < 2; z++)
          run_instr(op, z[0], d);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule